// File: doc/BRIEF.md
# Timekeeping Register Read Snapshot Buffer

This block sits between the byte-wide register port of a serial-bus protocol engine and the live time/date counters of a real-time clock. It keeps a shadow copy of the time and date registers. A host that reads several bytes in a row therefore sees one consistent instant, while the live counters keep advancing underneath. The shadow is reloaded only when the protocol engine reports a bus START or reports that its auto-incrementing register pointer has wrapped back to address 0. It is never reloaded in the middle of a multi-byte read.

Writes do not pass through the shadow. A data byte from the host goes to the live register file in the cycle that the protocol engine acknowledges it. A write to the seconds register also tells the counter block to clear its sub-second divider chain. Addresses above the time/date range are not shadowed: reads there return the live register file's data directly. A snapshot request can land in the same cycle as the once-per-second counter update. In that case the capture is delayed by one cycle, so that it holds the values after the update.

Top module: `rtc_snap_buf`

## Requirements
- R1: In a cycle where `startDet` is high and `secTick` is low, every shadow register loads the matching byte of `liveTime` at that clock edge. Byte i is `liveTime[8*i+7:8*i]` and is shadowed as address i.
- R2: In a cycle where `ptrWrap` is high and `secTick` is low, the shadow loads in the same way as in R1.
- R3: When `regAddr` is below NUM_TIME (7 by default), `rdData` returns the shadow byte for that address. Changes on `liveTime` do not show there until the next capture.
- R4: With no START, no wrap and no deferred capture pending, the shadow keeps its value.
- R5: In a cycle where `wrAck` is high, `liveWrEn` is high in that same cycle, with `liveWrAddr` equal to `regAddr` and `liveWrData` equal to `wrData`. In all other cycles `liveWrEn` is low.
- R6: `subSecReset` is high exactly in the cycles where `wrAck` is high and `regAddr` is 0, the seconds register.
- R7: When `regAddr` is NUM_TIME or higher, `rdData` equals `liveRdData` in the same cycle.
- R8: If a START or a wrap coincides with `secTick`, no capture takes place at that edge. The shadow instead loads `liveTime` at the following edge, which gives the post-update values.
- R9: While `rstN` is low, all shadow bytes reset to 0. `liveWrEn` and `subSecReset` stay low whenever `wrAck` is low.
- R10: A host write leaves the shadow unchanged. A read of the written time address still returns the previously captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startDet | input | 1 | One-cycle pulse: bus START detected |
| ptrWrap | input | 1 | One-cycle pulse: register pointer wrapped to 0 |
| secTick | input | 1 | Live counters take their 1 Hz update at this edge |
| regAddr | input | ADDR_W (5) | Current register pointer |
| wrAck | input | 1 | Write data byte acknowledged this cycle |
| wrData | input | DATA_W (8) | Host write byte |
| liveTime | input | NUM_TIME*DATA_W (56) | Live time/date registers, address i in byte i |
| liveRdData | input | DATA_W (8) | Live register file read data at `regAddr` |
| rdData | output | DATA_W (8) | Byte returned to the host |
| liveWrEn | output | 1 | Write strobe to the live register file |
| liveWrAddr | output | ADDR_W (5) | Write address to the live register file |
| liveWrData | output | DATA_W (8) | Write data to the live register file |
| subSecReset | output | 1 | Clear the sub-second divider chain |

## Verification
Several properties are checked on every cycle. After a capture request with no tick, the shadow equals the previous cycle's live image. After a request that coincides with a tick, the capture happens one cycle later. With no request, the shadow is stable. Write strobes and the seconds-reset strobe follow the acknowledge, and reads above the time range pass the live data straight through. Other points need the bench's own scenarios, because no single-cycle property can show them. These are: that a consistent older image is still returned after the live counters have moved on, that a write leaves the shadow unchanged, and that the reset image is all zero.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load shadow from live image this edge
    logic wrEn;      // forward host byte to live registers
    logic secReset;  // seconds written: clear sub-second chain
  } snapCtl_t;

  localparam int SECONDS_ADDR = 0;
endpackage

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              ptrWrap,
  input  logic              secTick,
  input  logic              wrAck,
  input  logic [ADDR_W-1:0] regAddr,
  output snapCtl_t          ctl
);
  logic snapReq;
  logic deferQ;

  assign snapReq = startDet | ptrWrap;

  // a request that meets the 1 Hz update waits one edge for fresh values
  always_ff @(posedge clk) begin
    if (!rstN) deferQ <= 1'b0;
    else       deferQ <= snapReq & secTick;
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = deferQ | (snapReq & ~secTick);
    ctl.wrEn     = wrAck;
    ctl.secReset = wrAck & (regAddr == ADDR_W'(SECONDS_ADDR));
  end
endmodule

// File: rtl/rtc_snap_dp.sv
module rtc_snap_dp
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int NUM_TIME = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  snapCtl_t                   ctl,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NUM_TIME*DATA_W-1:0] liveTime,
  input  logic [DATA_W-1:0]          liveRdData,
  output logic [NUM_TIME*DATA_W-1:0] shadowBus,
  output logic [DATA_W-1:0]          rdData,
  output logic                       liveWrEn,
  output logic [ADDR_W-1:0]          liveWrAddr,
  output logic [DATA_W-1:0]          liveWrData,
  output logic                       subSecReset
);
  for (genvar i = 0; i < NUM_TIME; i++) begin : g_shadow
    logic [DATA_W-1:0] shadowQ;
    always_ff @(posedge clk) begin
      if (!rstN)            shadowQ <= '0;
      else if (ctl.capture) shadowQ <= liveTime[i*DATA_W +: DATA_W];
    end
    assign shadowBus[i*DATA_W +: DATA_W] = shadowQ;
  end

  always_comb begin
    rdData = liveRdData;
    for (int i = 0; i < NUM_TIME; i++) begin
      if (regAddr == ADDR_W'(i)) rdData = shadowBus[i*DATA_W +: DATA_W];
    end
  end

  assign liveWrEn    = ctl.wrEn;
  assign liveWrAddr  = regAddr;
  assign liveWrData  = wrData;
  assign subSecReset = ctl.secReset;
endmodule

// File: rtl/rtc_snap_buf.sv
module rtc_snap_buf
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int NUM_TIME = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startDet,
  input  logic                       ptrWrap,
  input  logic                       secTick,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic                       wrAck,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NUM_TIME*DATA_W-1:0] liveTime,
  input  logic [DATA_W-1:0]          liveRdData,
  output logic [DATA_W-1:0]          rdData,
  output logic                       liveWrEn,
  output logic [ADDR_W-1:0]          liveWrAddr,
  output logic [DATA_W-1:0]          liveWrData,
  output logic                       subSecReset
);
  snapCtl_t                   ctl;
  logic [NUM_TIME*DATA_W-1:0] shadowBus;

  rtc_snap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .ptrWrap(ptrWrap),
    .secTick(secTick), .wrAck(wrAck), .regAddr(regAddr), .ctl(ctl)
  );

  rtc_snap_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TIME(NUM_TIME)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regAddr(regAddr), .wrData(wrData),
    .liveTime(liveTime), .liveRdData(liveRdData), .shadowBus(shadowBus),
    .rdData(rdData), .liveWrEn(liveWrEn), .liveWrAddr(liveWrAddr),
    .liveWrData(liveWrData), .subSecReset(subSecReset)
  );
endmodule

// File: rtl/rtc_snap_buf_chk.sv
module rtc_snap_buf_chk #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int NUM_TIME = 7
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       startDet,
  input logic                       ptrWrap,
  input logic                       secTick,
  input logic [ADDR_W-1:0]          regAddr,
  input logic                       wrAck,
  input logic [DATA_W-1:0]          wrData,
  input logic [NUM_TIME*DATA_W-1:0] liveTime,
  input logic [DATA_W-1:0]          liveRdData,
  input logic [NUM_TIME*DATA_W-1:0] shadowBus,
  input logic [DATA_W-1:0]          rdData,
  input logic                       liveWrEn,
  input logic [ADDR_W-1:0]          liveWrAddr,
  input logic [DATA_W-1:0]          liveWrData,
  input logic                       subSecReset
);
  logic chkDefer;
  always_ff @(posedge clk) begin
    if (!rstN) chkDefer <= 1'b0;
    else       chkDefer <= (startDet | ptrWrap) & secTick;
  end

  a_r1_start_capture: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !secTick) |=> (shadowBus == $past(liveTime)));

  a_r2_wrap_capture: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWrap && !secTick) |=> (shadowBus == $past(liveTime)));

  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!startDet && !ptrWrap && !chkDefer) |=> $stable(shadowBus));

  a_r8_deferred_capture: assert property (@(posedge clk) disable iff (!rstN)
    ((startDet || ptrWrap) && secTick) |=> ##1 (shadowBus == $past(liveTime)));

  a_r5_write_forward: assert property (@(posedge clk) disable iff (!rstN)
    wrAck |-> (liveWrEn && liveWrAddr == regAddr && liveWrData == wrData));

  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrAck |-> (!liveWrEn && !subSecReset));

  a_r6_seconds_reset: assert property (@(posedge clk) disable iff (!rstN)
    subSecReset |-> (liveWrEn && liveWrAddr == '0));

  a_r7_live_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_W'(NUM_TIME)) |-> (rdData == liveRdData));
endmodule

bind rtc_snap_buf rtc_snap_buf_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TIME(NUM_TIME)
) u_chk (.*);

// File: tb/rtc_snap_buf_tb.sv
module rtc_snap_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int NT     = 7;

  logic clk = 1'b0;
  logic rstN, startDet, ptrWrap, secTick, wrAck;
  logic [ADDR_W-1:0]    regAddr;
  logic [DATA_W-1:0]    wrData, liveRdData, rdData, liveWrData, liveSalt;
  logic [NT*DATA_W-1:0] liveTime;
  logic                 liveWrEn, subSecReset;
  logic [ADDR_W-1:0]    liveWrAddr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    int          kind;    // 0: rdData, 1: write outputs
    logic [31:0] exp;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign liveRdData = 8'hC0 ^ {3'b000, regAddr} ^ liveSalt;

  rtc_snap_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TIME(NT)) u_dut (
    .clk(clk), .rstN(rstN), .startDet(startDet), .ptrWrap(ptrWrap),
    .secTick(secTick), .regAddr(regAddr), .wrAck(wrAck), .wrData(wrData),
    .liveTime(liveTime), .liveRdData(liveRdData), .rdData(rdData),
    .liveWrEn(liveWrEn), .liveWrAddr(liveWrAddr), .liveWrData(liveWrData),
    .subSecReset(subSecReset)
  );

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        if (it.kind == 0) got = {24'b0, rdData};
        else got = {17'b0, liveWrEn, subSecReset, liveWrAddr, liveWrData};
        compared++;
        if (got !== it.exp) begin
          mismatched++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [NT*DATA_W-1:0] img(input logic [7:0] base);
    logic [NT*DATA_W-1:0] v;
    for (int i = 0; i < NT; i++) v[i*DATA_W +: DATA_W] = base + 8'(i * 3);
    return v;
  endfunction

  task automatic expRead(input string tag, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] e);
    item_t it;
    regAddr = a;
    it.tag = tag; it.kind = 0; it.exp = {24'b0, e};
    q.push_back(it);
    step();
  endtask

  task automatic readImage(input string tag, input logic [NT*DATA_W-1:0] v);
    for (int i = 0; i < NT; i++) expRead(tag, ADDR_W'(i), v[i*DATA_W +: DATA_W]);
  endtask

  task automatic doWrite(input string tag, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic secExp);
    item_t it;
    regAddr = a; wrData = d; wrAck = 1'b1;
    it.tag = tag; it.kind = 1; it.exp = {17'b0, 1'b1, secExp, a, d};
    q.push_back(it);
    step();
    wrAck = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [NT*DATA_W-1:0] imgA, imgB, imgC, imgD;
    item_t it;
    imgA = img(8'h10); imgB = img(8'h40); imgC = img(8'h70); imgD = img(8'hA0);
    rstN = 0; startDet = 0; ptrWrap = 0; secTick = 0; wrAck = 0;
    regAddr = '0; wrData = '0; liveSalt = 8'h00; liveTime = imgA;
    repeat (3) step();
    // R9: reset image is zero, even with live data present
    readImage("R9 reset shadow", '0);
    rstN = 1;
    step();
    it.tag = "R9 no write strobe idle"; it.kind = 1;
    it.exp = {17'b0, 1'b0, 1'b0, regAddr, wrData};
    q.push_back(it);
    step();

    // R1: START capture
    startDet = 1; step(); startDet = 0;
    readImage("R1 start capture", imgA);
    // R3: live moves on, shadow does not
    liveTime = imgB;
    readImage("R3 shadow isolated from live", imgA);

    // R2: wrap capture
    ptrWrap = 1; step(); ptrWrap = 0;
    readImage("R2 wrap capture", imgB);

    // R4: hold with no request over several cycles
    liveTime = imgC;
    repeat (5) step();
    readImage("R4 shadow hold", imgB);

    // R7: pass-through above the time range
    expRead("R7 live read addr 9", 5'd9, 8'hC0 ^ 8'd9);
    liveSalt = 8'h3C;
    expRead("R7 live read follows live", 5'd9, 8'hC0 ^ 8'd9 ^ 8'h3C);
    expRead("R7 live read addr 7", 5'd7, 8'hC0 ^ 8'd7 ^ 8'h3C);

    // R5/R6: writes forwarded at the acknowledge
    doWrite("R5 write forward addr 3", 5'd3, 8'h55, 1'b0);
    doWrite("R6 seconds write resets chain", 5'd0, 8'h59, 1'b1);
    doWrite("R5 write forward addr 12", 5'd12, 8'hA7, 1'b0);
    // R10: shadow untouched by writes
    expRead("R10 write does not touch shadow", 5'd3, imgB[3*DATA_W +: DATA_W]);
    expRead("R10 seconds shadow kept", 5'd0, imgB[0 +: DATA_W]);

    // R8: START meets 1 Hz update
    regAddr = 5'd2;
    startDet = 1; secTick = 1;
    step();
    startDet = 0; secTick = 0; liveTime = imgD;   // post-update values
    it.tag = "R8 no capture on tick edge"; it.kind = 0;
    it.exp = {24'b0, imgB[2*DATA_W +: DATA_W]};
    q.push_back(it);
    step();
    liveTime = imgC;
    readImage("R8 deferred capture post-update", imgD);

    // R8 with a wrap request
    ptrWrap = 1; secTick = 1; liveTime = imgA;
    step();
    ptrWrap = 0; secTick = 0; liveTime = imgB;
    step();
    liveTime = imgC;
    readImage("R8 deferred wrap capture", imgB);

    step(); step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule